// File: doc/BRIEF.md
# MESI Line Directory Controller

This block is the directory controller for a single line of a unified second-level cache that several private first-level caches share. It records whether the line is idle, shared by a set of caches (kept as a bit-vector), or held exclusively by one owner (kept as an owner index). It also holds the line's data word. Read-share (GETS), read-for-ownership (GETX) and owner writeback (PUTX) requests come in. For each one the directory sends the required coherence messages: data grants that carry an acknowledgement count, invalidations, and forwards to the current owner.

Every ownership change blocks the line until the new holder returns an explicit unblock. While the line is blocked, one further request is parked in a retry slot. Any request after that meets back-pressure. The parked request is therefore never dropped, and it is served only after the transfer has settled. This ordering also resolves a late writeback that races with a transfer: once the new owner is recorded, the old owner's writeback is no longer from the owner, so it is acknowledged and thrown away. Both the request and the response interfaces are valid/ready. A request moves when `req_valid` and `req_ready` are both high at a rising edge. A response message moves when `rsp_valid` and `rsp_ready` are both high. While `rsp_valid` is high and `rsp_ready` is low, every response field holds steady. `req_ready` falls only while the retry slot is occupied. The unblock input is a plain single-cycle pulse.

Top module: `dirent_line`

## Requirements
- R1: After reset no response is offered (`rsp_valid` low), `req_ready` is high, the line is idle and the data word is zero.
- R2: A GETS (req kind 0) or GETX (req kind 1) to an idle line, or to a line owned by the requester itself, answers with exclusive data (rsp kind 1) to the requester with ack count 0 and the stored word. The line then blocks until the requester unblocks, and the requester becomes owner.
- R3: A GETS to a shared line answers with shared data (rsp kind 0) carrying the stored word, does not block the line, and adds the requester to the sharer set.
- R4: A GETS to a line owned by another cache sends forward-for-read (rsp kind 5) to the owner and blocks. On the requester's unblock, the old owner and the requester become the only sharers.
- R5: A GETX to a shared line first sends exclusive data (rsp kind 1) with an ack count equal to the number of sharers other than the requester. It then sends one invalidation (rsp kind 2) to each such sharer in ascending index order, and blocks. On unblock the sharer set is cleared and the requester is owner.
- R6: A GETX to a line owned by another cache sends forward-for-write (rsp kind 3) to the owner and blocks. On the requester's unblock the owner becomes the requester.
- R7: A PUTX (req kind 2) from the recorded owner stores its data word, answers with a writeback acknowledgement (rsp kind 4), and returns the line to idle.
- R8: A PUTX from any cache that is not the recorded owner is acknowledged (rsp kind 4) and changes neither the owner nor the data word.
- R9: While the line is blocked, one request is parked and `req_ready` stays low until it is served, with no response offered. An unblock from a source other than the awaited requester is ignored. The parked request is served on the second rising edge after the matching unblock edge.
- R10: Response fields hold steady while `rsp_valid` is high and `rsp_ready` low. Exactly one message retires per handshake.
- R11: On every message `rsp_peer` is the requester of the request being served. `rsp_acks` is zero on every kind except exclusive data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_kind | input | 2 | 0 GETS, 1 GETX, 2 PUTX |
| req_src | input | $clog2(NCORE) | Requesting cache index |
| req_data | input | DW | Writeback word for PUTX |
| rsp_valid | output | 1 | Message offered |
| rsp_ready | input | 1 | Message taken when high with rsp_valid |
| rsp_kind | output | 3 | 0 data, 1 exclusive data, 2 invalidate, 3 forward-for-write, 4 writeback ack, 5 forward-for-read |
| rsp_dst | output | $clog2(NCORE) | Cache the message goes to |
| rsp_peer | output | $clog2(NCORE) | Requester the message is on behalf of |
| rsp_acks | output | $clog2(NCORE+1) | Invalidation acks the requester must collect |
| rsp_data | output | DW | Line word on data messages, zero otherwise |
| unb_valid | input | 1 | Unblock pulse from the new holder |
| unb_src | input | $clog2(NCORE) | Cache sending the unblock |

## Verification
A request accepted at a rising edge with the line free puts its first message on the response port right after that edge. Each further message follows one cycle after the previous handshake. A request parked during a block shows its first message only after the second rising edge past the matching unblock edge. The bench drives at falling edges and samples each expected message at the falling edge that follows the edge where it is due. It leaves one idle cycle between table rows so that no request is parked by accident. It also checks that `rsp_valid` is low exactly where a message sequence should have ended or not yet begun.

// File: rtl/dirent_pkg.sv
package dirent_pkg;

  // Request kinds as seen on req_kind
  typedef enum logic [1:0] {
    RQ_GETS = 2'd0,
    RQ_GETX = 2'd1,
    RQ_PUTX = 2'd2
  } rq_kind_e;

  // Outgoing message kinds as seen on rsp_kind
  typedef enum logic [2:0] {
    MS_DATA      = 3'd0,
    MS_DATA_EXCL = 3'd1,
    MS_INV       = 3'd2,
    MS_FWD_GETX  = 3'd3,
    MS_WB_ACK    = 3'd4,
    MS_FWD_GETS  = 3'd5
  } ms_kind_e;

  // Stable directory states of the line
  typedef enum logic [1:0] {
    LN_IDLE   = 2'd0,
    LN_SHARED = 2'd1,
    LN_OWNED  = 2'd2
  } ln_state_e;

endpackage

// File: rtl/dirent_slot.sv
// One-entry retry slot: a request that arrives while the line is busy is
// parked here; a parked request is served before any new one.
module dirent_slot #(
  parameter int IDW = 2,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [1:0]     in_kind,
  input  logic [IDW-1:0] in_src,
  input  logic [DW-1:0]  in_data,
  input  logic           free,
  output logic           go,
  output logic [1:0]     go_kind,
  output logic [IDW-1:0] go_src,
  output logic [DW-1:0]  go_data
);

  logic           held_q;
  logic [1:0]     kind_q;
  logic [IDW-1:0] src_q;
  logic [DW-1:0]  data_q;

  assign in_ready = !held_q;
  assign go       = free && (held_q || in_valid);
  assign go_kind  = held_q ? kind_q : in_kind;
  assign go_src   = held_q ? src_q  : in_src;
  assign go_data  = held_q ? data_q : in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      kind_q <= '0;
      src_q  <= '0;
      data_q <= '0;
    end else if (free && held_q) begin
      held_q <= 1'b0;
    end else if (!free && !held_q && in_valid) begin
      held_q <= 1'b1;
      kind_q <= in_kind;
      src_q  <= in_src;
      data_q <= in_data;
    end
  end

endmodule

// File: rtl/dirent_seq.sv
// Message sequencer: emits the leading message of a job, then one
// invalidation per set bit of the mask, lowest index first.
module dirent_seq
  import dirent_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int IDW   = 2,
  parameter int CW    = 3,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  ms_kind_e         ld_kind,
  input  logic [IDW-1:0]   ld_dst,
  input  logic [IDW-1:0]   ld_peer,
  input  logic [CW-1:0]    ld_acks,
  input  logic [DW-1:0]    ld_data,
  input  logic [NCORE-1:0] ld_mask,
  output logic             idle,
  output logic             out_valid,
  input  logic             out_ready,
  output ms_kind_e         out_kind,
  output logic [IDW-1:0]   out_dst,
  output logic [IDW-1:0]   out_peer,
  output logic [CW-1:0]    out_acks,
  output logic [DW-1:0]    out_data
);

  logic             lead_q;
  ms_kind_e         kind_q;
  logic [IDW-1:0]   dst_q;
  logic [IDW-1:0]   peer_q;
  logic [CW-1:0]    acks_q;
  logic [DW-1:0]    data_q;
  logic [NCORE-1:0] mask_q;
  logic [IDW-1:0]   low_idx;
  logic             fire;

  always_comb begin
    low_idx = '0;
    for (int i = NCORE - 1; i >= 0; i--) begin
      if (mask_q[i]) low_idx = IDW'(i);
    end
  end

  assign out_valid = lead_q || (|mask_q);
  assign idle      = !out_valid;
  assign out_kind  = lead_q ? kind_q : MS_INV;
  assign out_dst   = lead_q ? dst_q  : low_idx;
  assign out_peer  = peer_q;
  assign out_acks  = lead_q ? acks_q : '0;
  assign out_data  = lead_q ? data_q : '0;
  assign fire      = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_q <= 1'b0;
      kind_q <= MS_WB_ACK;
      dst_q  <= '0;
      peer_q <= '0;
      acks_q <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else if (load) begin
      lead_q <= 1'b1;
      kind_q <= ld_kind;
      dst_q  <= ld_dst;
      peer_q <= ld_peer;
      acks_q <= ld_acks;
      data_q <= ld_data;
      mask_q <= ld_mask;
    end else if (fire) begin
      if (lead_q) lead_q <= 1'b0;
      else        mask_q[low_idx] <= 1'b0;
    end
  end

endmodule

// File: rtl/dirent_ctl.sv
// Directory state for the line: stable state, sharers, owner, data word,
// and the pending-transfer record that blocks the line until unblock.
module dirent_ctl
  import dirent_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int IDW   = 2,
  parameter int CW    = 3,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  rq_kind_e         kind,
  input  logic [IDW-1:0]   src,
  input  logic [DW-1:0]    data,
  input  logic             unb_valid,
  input  logic [IDW-1:0]   unb_src,
  output logic             blocked,
  output logic             load,
  output ms_kind_e         ld_kind,
  output logic [IDW-1:0]   ld_dst,
  output logic [IDW-1:0]   ld_peer,
  output logic [CW-1:0]    ld_acks,
  output logic [DW-1:0]    ld_data,
  output logic [NCORE-1:0] ld_mask
);

  ln_state_e        st_q, st_d;
  logic [IDW-1:0]   owner_q;
  logic [NCORE-1:0] sharers_q, sh_d;
  logic [DW-1:0]    word_q, word_d;
  logic             blk_q;
  logic [IDW-1:0]   blk_src_q;
  logic             blk_sh_q;
  logic [IDW-1:0]   blk_prev_q;

  logic [NCORE-1:0] src_bit;
  logic [NCORE-1:0] others;
  logic [CW-1:0]    oth_cnt;
  logic             do_excl, do_blk, to_sh, unb_ok;

  assign src_bit = NCORE'(1) << src;
  assign others  = sharers_q & ~src_bit;
  assign unb_ok  = blk_q && unb_valid && (unb_src == blk_src_q);
  assign blocked = blk_q;
  assign load    = go;
  assign ld_peer = src;

  always_comb begin
    oth_cnt = '0;
    for (int i = 0; i < NCORE; i++) begin
      if (others[i]) oth_cnt = oth_cnt + CW'(1);
    end
  end

  always_comb begin
    ld_kind = MS_WB_ACK;
    ld_dst  = src;
    ld_acks = '0;
    ld_data = '0;
    ld_mask = '0;
    do_excl = 1'b0;
    do_blk  = 1'b0;
    to_sh   = 1'b0;
    st_d    = st_q;
    sh_d    = sharers_q;
    word_d  = word_q;
    case (kind)
      RQ_GETS: begin
        case (st_q)
          LN_SHARED: begin
            ld_kind = MS_DATA;
            ld_data = word_q;
            sh_d    = sharers_q | src_bit;
          end
          LN_OWNED: begin
            if (owner_q != src) begin
              ld_kind = MS_FWD_GETS;
              ld_dst  = owner_q;
              do_blk  = 1'b1;
              to_sh   = 1'b1;
            end else begin
              do_excl = 1'b1;
            end
          end
          default: do_excl = 1'b1;
        endcase
      end
      RQ_GETX: begin
        if (st_q == LN_SHARED) begin
          ld_kind = MS_DATA_EXCL;
          ld_data = word_q;
          ld_acks = oth_cnt;
          ld_mask = others;
          do_blk  = 1'b1;
        end else if (st_q == LN_OWNED && owner_q != src) begin
          ld_kind = MS_FWD_GETX;
          ld_dst  = owner_q;
          do_blk  = 1'b1;
        end else begin
          do_excl = 1'b1;
        end
      end
      RQ_PUTX: begin
        if (st_q == LN_OWNED && owner_q == src) begin
          word_d = data;
          st_d   = LN_IDLE;
        end
      end
      default: ;
    endcase
    if (do_excl) begin
      ld_kind = MS_DATA_EXCL;
      ld_data = word_q;
      do_blk  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= LN_IDLE;
      owner_q    <= '0;
      sharers_q  <= '0;
      word_q     <= '0;
      blk_q      <= 1'b0;
      blk_src_q  <= '0;
      blk_sh_q   <= 1'b0;
      blk_prev_q <= '0;
    end else if (unb_ok) begin
      blk_q <= 1'b0;
      if (blk_sh_q) begin
        st_q      <= LN_SHARED;
        sharers_q <= (NCORE'(1) << blk_prev_q) | (NCORE'(1) << blk_src_q);
      end else begin
        st_q      <= LN_OWNED;
        owner_q   <= blk_src_q;
        sharers_q <= '0;
      end
    end else if (go) begin
      st_q      <= st_d;
      sharers_q <= sh_d;
      word_q    <= word_d;
      if (do_blk) begin
        blk_q      <= 1'b1;
        blk_src_q  <= src;
        blk_sh_q   <= to_sh;
        blk_prev_q <= owner_q;
      end
    end
  end

endmodule

// File: rtl/dirent_line.sv
module dirent_line
  import dirent_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int DW    = 32,
  localparam int IDW  = $clog2(NCORE),
  localparam int CW   = $clog2(NCORE + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [1:0]     req_kind,
  input  logic [IDW-1:0] req_src,
  input  logic [DW-1:0]  req_data,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [2:0]     rsp_kind,
  output logic [IDW-1:0] rsp_dst,
  output logic [IDW-1:0] rsp_peer,
  output logic [CW-1:0]  rsp_acks,
  output logic [DW-1:0]  rsp_data,
  input  logic           unb_valid,
  input  logic [IDW-1:0] unb_src
);

  logic             free, go, blocked, seq_idle, load;
  logic [1:0]       go_kind;
  logic [IDW-1:0]   go_src;
  logic [DW-1:0]    go_data;
  ms_kind_e         ld_kind, out_kind;
  logic [IDW-1:0]   ld_dst, ld_peer;
  logic [CW-1:0]    ld_acks;
  logic [DW-1:0]    ld_data;
  logic [NCORE-1:0] ld_mask;

  assign free     = !blocked && seq_idle;
  assign rsp_kind = out_kind;

  dirent_slot #(.IDW(IDW), .DW(DW)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_kind  (req_kind),
    .in_src   (req_src),
    .in_data  (req_data),
    .free     (free),
    .go       (go),
    .go_kind  (go_kind),
    .go_src   (go_src),
    .go_data  (go_data)
  );

  dirent_ctl #(.NCORE(NCORE), .IDW(IDW), .CW(CW), .DW(DW)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .kind      (rq_kind_e'(go_kind)),
    .src       (go_src),
    .data      (go_data),
    .unb_valid (unb_valid),
    .unb_src   (unb_src),
    .blocked   (blocked),
    .load      (load),
    .ld_kind   (ld_kind),
    .ld_dst    (ld_dst),
    .ld_peer   (ld_peer),
    .ld_acks   (ld_acks),
    .ld_data   (ld_data),
    .ld_mask   (ld_mask)
  );

  dirent_seq #(.NCORE(NCORE), .IDW(IDW), .CW(CW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .ld_kind   (ld_kind),
    .ld_dst    (ld_dst),
    .ld_peer   (ld_peer),
    .ld_acks   (ld_acks),
    .ld_data   (ld_data),
    .ld_mask   (ld_mask),
    .idle      (seq_idle),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_kind  (out_kind),
    .out_dst   (rsp_dst),
    .out_peer  (rsp_peer),
    .out_acks  (rsp_acks),
    .out_data  (rsp_data)
  );

endmodule

// File: rtl/dirent_line_chk.sv
module dirent_line_chk #(
  parameter int NCORE = 4,
  parameter int DW    = 32,
  localparam int IDW  = $clog2(NCORE),
  localparam int CW   = $clog2(NCORE + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rsp_valid,
  input logic           rsp_ready,
  input logic [2:0]     rsp_kind,
  input logic [IDW-1:0] rsp_dst,
  input logic [IDW-1:0] rsp_peer,
  input logic [CW-1:0]  rsp_acks,
  input logic [DW-1:0]  rsp_data
);

  // R10: a stalled message keeps every field
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_kind) && $stable(rsp_dst)
      && $stable(rsp_peer) && $stable(rsp_acks) && $stable(rsp_data));

  // R5: an invalidation never targets the requester
  a_r5_inv_not_requester: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == 3'd2 |-> rsp_dst != rsp_peer);

  // R5: ack count on exclusive data is below the number of caches
  a_r5_acks_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == 3'd1 |-> rsp_acks < CW'(NCORE));

  // R4, R6: a forward always goes to a cache other than the requester
  a_r6_fwd_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_kind == 3'd3 || rsp_kind == 3'd5) |-> rsp_dst != rsp_peer);

  // R11: only exclusive data carries a nonzero ack count
  a_r11_acks_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind != 3'd1 |-> rsp_acks == '0);

  // R11: no message kind outside the defined set is offered
  a_r11_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_kind <= 3'd5);

endmodule

bind dirent_line dirent_line_chk #(.NCORE(NCORE), .DW(DW)) u_chk (.*);

// File: tb/test_dirent_line.sv
`timescale 1ns/1ps
module test_dirent_line;

  localparam int NCORE = 4;
  localparam int DW    = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_src = '0;
  logic [31:0] req_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [2:0]  rsp_kind;
  logic [1:0]  rsp_dst;
  logic [1:0]  rsp_peer;
  logic [2:0]  rsp_acks;
  logic [31:0] rsp_data;
  logic        unb_valid = 1'b0;
  logic [1:0]  unb_src = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dirent_line #(.NCORE(NCORE), .DW(DW)) i_dirent_line (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_src(req_src), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
    .rsp_dst(rsp_dst), .rsp_peer(rsp_peer), .rsp_acks(rsp_acks), .rsp_data(rsp_data),
    .unb_valid(unb_valid), .unb_src(unb_src)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  src;
    logic [31:0] data;
    logic [2:0]  ek;
    logic [1:0]  edst;
    logic [2:0]  eacks;
    logic [31:0] edata;
    logic [3:0]  mask;
    logic        unb;
    logic [3:0]  rq;
  } row_t;

  localparam int NROW = 11;
  localparam row_t ROWS [NROW] = '{
    '{2'd0, 2'd1, 32'h0,    3'd1, 2'd1, 3'd0, 32'h0,    4'b0000, 1'b1, 4'd2}, // R2 idle GETS -> exclusive
    '{2'd0, 2'd2, 32'h0,    3'd5, 2'd1, 3'd0, 32'h0,    4'b0000, 1'b1, 4'd4}, // R4 forward for read
    '{2'd0, 2'd3, 32'h0,    3'd0, 2'd3, 3'd0, 32'h0,    4'b0000, 1'b0, 4'd3}, // R3 shared read
    '{2'd1, 2'd2, 32'h0,    3'd1, 2'd2, 3'd2, 32'h0,    4'b1010, 1'b1, 4'd5}, // R5 GETX on sharers
    '{2'd2, 2'd1, 32'hAA,   3'd4, 2'd1, 3'd0, 32'h0,    4'b0000, 1'b0, 4'd8}, // R8 stale PUTX
    '{2'd1, 2'd0, 32'h0,    3'd3, 2'd2, 3'd0, 32'h0,    4'b0000, 1'b1, 4'd6}, // R6 forward, owner still 2
    '{2'd2, 2'd0, 32'h1234, 3'd4, 2'd0, 3'd0, 32'h0,    4'b0000, 1'b0, 4'd7}, // R7 owner writeback
    '{2'd1, 2'd3, 32'h0,    3'd1, 2'd3, 3'd0, 32'h1234, 4'b0000, 1'b1, 4'd7}, // R7 idle after writeback
    '{2'd2, 2'd3, 32'h55,   3'd4, 2'd3, 3'd0, 32'h0,    4'b0000, 1'b0, 4'd7}, // R7 writeback 0x55
    '{2'd2, 2'd2, 32'hDEAD, 3'd4, 2'd2, 3'd0, 32'h0,    4'b0000, 1'b0, 4'd8}, // R8 stale PUTX on idle line
    '{2'd0, 2'd0, 32'h0,    3'd1, 2'd0, 3'd0, 32'h55,   4'b0000, 1'b1, 4'd2}  // R2 word kept at 0x55
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send_req(input logic [1:0] k, input logic [1:0] s, input logic [31:0] d);
    req_kind  = k;
    req_src   = s;
    req_data  = d;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_unb(input logic [1:0] s);
    unb_valid = 1'b1;
    unb_src   = s;
    @(negedge clk);
    unb_valid = 1'b0;
  endtask

  // check the message currently offered, then step to the next falling edge
  task automatic expect_msg(input string tag, input logic [2:0] k, input logic [1:0] dst,
                            input logic [1:0] peer, input logic [2:0] acks,
                            input logic [31:0] data);
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " kind"},  32'(rsp_kind),  32'(k));
    chk({tag, " dst"},   32'(rsp_dst),   32'(dst));
    chk({tag, " peer (R11)"}, 32'(rsp_peer), 32'(peer));
    chk({tag, " acks"},  32'(rsp_acks),  32'(acks));
    chk({tag, " data"},  rsp_data,       data);
    @(negedge clk);
  endtask

  initial begin
    repeat (25000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 reset req_ready", 32'(req_ready), 32'd1);
    @(negedge clk);

    for (int r = 0; r < NROW; r++) begin
      string tag;
      tag = $sformatf("R%0d row %0d", ROWS[r].rq, r);
      send_req(ROWS[r].kind, ROWS[r].src, ROWS[r].data);
      expect_msg(tag, ROWS[r].ek, ROWS[r].edst, ROWS[r].src, ROWS[r].eacks, ROWS[r].edata);
      for (int i = 0; i < NCORE; i++) begin
        if (ROWS[r].mask[i]) expect_msg({tag, " inv"}, 3'd2, 2'(i), ROWS[r].src, 3'd0, 32'h0);
      end
      chk({tag, " end of messages"}, 32'(rsp_valid), 32'd0);
      if (ROWS[r].unb) pulse_unb(ROWS[r].src);
    end

    // R9 / R8: writeback from the old owner races a forward-for-write
    send_req(2'd1, 2'd1, 32'h0);
    expect_msg("R6 race forward", 3'd3, 2'd0, 2'd1, 3'd0, 32'h0);
    req_kind = 2'd2; req_src = 2'd0; req_data = 32'h66; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 slot full req_ready", 32'(req_ready), 32'd0);
    chk("R9 blocked no response", 32'(rsp_valid), 32'd0);
    repeat (3) begin
      @(negedge clk);
      chk("R9 blocked still silent", 32'(rsp_valid), 32'd0);
    end
    pulse_unb(2'd2);
    chk("R9 wrong unblock ignored rsp", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    chk("R9 wrong unblock ignored ready", 32'(req_ready), 32'd0);
    chk("R9 wrong unblock ignored silent", 32'(rsp_valid), 32'd0);
    pulse_unb(2'd1);
    chk("R9 parked not yet served", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    chk("R9 slot drained req_ready", 32'(req_ready), 32'd1);
    expect_msg("R8 stale race PUTX ack", 3'd4, 2'd0, 2'd0, 3'd0, 32'h0);
    send_req(2'd1, 2'd2, 32'h0);
    expect_msg("R8 owner kept after race", 3'd3, 2'd1, 2'd2, 3'd0, 32'h0);
    pulse_unb(2'd2);

    // R10: back-pressure across a multi-message sequence
    send_req(2'd0, 2'd3, 32'h0);
    expect_msg("R4 forward for read", 3'd5, 2'd2, 2'd3, 3'd0, 32'h0);
    pulse_unb(2'd3);
    send_req(2'd0, 2'd0, 32'h0);
    expect_msg("R3 shared add", 3'd0, 2'd0, 2'd0, 3'd0, 32'h55);
    rsp_ready = 1'b0;
    send_req(2'd1, 2'd1, 32'h0);
    repeat (3) begin
      chk("R10 stalled valid", 32'(rsp_valid), 32'd1);
      chk("R10 stalled kind", 32'(rsp_kind), 32'd1);
      chk("R10 stalled acks", 32'(rsp_acks), 32'd3);
      chk("R10 stalled dst", 32'(rsp_dst), 32'd1);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    expect_msg("R5 data after stall", 3'd1, 2'd1, 2'd1, 3'd3, 32'h55);
    expect_msg("R5 inv 0", 3'd2, 2'd0, 2'd1, 3'd0, 32'h0);
    expect_msg("R5 inv 2", 3'd2, 2'd2, 2'd1, 3'd0, 32'h0);
    expect_msg("R5 inv 3", 3'd2, 2'd3, 2'd1, 3'd0, 32'h0);
    chk("R10 one message per handshake", 32'(rsp_valid), 32'd0);
    pulse_unb(2'd1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule